// File: doc/BRIEF.md
# Embedded-Clock Deserializer Lock Detector

This block sits behind a bit-rate sampler on the receive side of a serial link. The sender packs each 16-bit word into an 18-bit frame. A frame is a high start bit, then the data bits with the least significant bit first, then a low stop bit. The stop and start bits together form the only clock edge the receiver is given: a 0 followed by a 1 at the frame boundary. The block finds which of the 18 bit phases carries that edge and declares lock once the phase is certain. It then delivers each word together with a one-cycle strobe.

The alignment search watches all 18 phases in parallel. A phase stays a candidate only while every frame shows a 0-to-1 step at it. Lock needs two things: exactly one candidate is left, and it has held for a programmable number of frames. This rule treats a dedicated sync pattern and ordinary varied traffic the same way. If a repeating pattern leaves several candidates, lock is refused until the pattern changes. After lock, two consecutive frames without the edge drop the lock and restart the search with no outside help.

The lock flag is active low. A receive power-down input clears all search and lock state. An output-enable input and the power-down input together decide whether the outputs are driven. When they are not driven, an output-drive flag goes low and the data, strobe and lock outputs rest at fixed inactive values for the pad ring.

Top module: `edser_lock_rx`

## Requirements
- R1: A frame is start bit 1 at frame bit 0, data bits 0..15 at frame bits 1..16, and stop bit 0 at frame bit 17. While locked, `word_stb` is high for exactly one clock, starting in the cycle after the edge that samples the stop bit. In that same cycle `word_out` shows the data of that frame.
- R2: After reset, `lock_n` is 1 and no strobe appears. Lock is not declared before LOCK_FRAMES (default 150) complete frames have shown the edge at one single phase.
- R3: `lock_n` falls in the same cycle as the first strobe after lock is qualified. No strobe appears while the search is still running.
- R4: If more than one phase keeps showing a 0-to-1 step in every frame, `lock_n` stays 1, however many frames pass. Once the pattern changes so that only one phase is left, lock follows within two frames.
- R5: While locked, one frame with the boundary edge missing is tolerated and lock is kept. A second consecutive missing edge sets `lock_n` to 1 in the cycle after the missing start bit is sampled, and the search restarts by itself.
- R6: While `rx_pwr_n` is 0, `out_oe` is 0, `word_out` is 0, `word_stb` is 0 and `lock_n` is 1, and all search, phase and lock state is cleared. After `rx_pwr_n` returns to 1, lock is only gained again through a full search.
- R7: While `out_en` is 0, `out_oe` is 0, `word_out` is 0, `word_stb` is 0 and `lock_n` is 1, but the internal state keeps running. When `out_en` returns to 1, the outputs show the current lock state and the latest word at once.
- R8: Cycles with `bit_vld` at 0 are ignored. They neither advance the frame phase nor count as bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_bit | input | 1 | Sampled serial bit |
| bit_vld | input | 1 | `ser_bit` holds a new bit this cycle |
| rx_pwr_n | input | 1 | Receive power-down, active low |
| out_en | input | 1 | Output enable, active high |
| word_out | output | 16 | Recovered parallel word (0 when not driven) |
| word_stb | output | 1 | One-cycle strobe for each delivered word |
| lock_n | output | 1 | Lock flag, active low (1 when not driven) |
| out_oe | output | 1 | Output drive enable for the pads |

## Verification
The bench builds the block with its default values: 16 data bits, a lock threshold of 150 frames and a miss limit of 2. With the full threshold, the frame in which lock appears can be checked exactly, one frame early and one frame late. A sync run of 150 frames must leave the lock flag high, and the 151st frame must bring the first strobe. Runs of a few hundred frames then cover loss of lock, pattern rejection and re-initialisation after power-down, all within the cycle budget.

// File: rtl/edlk_pkg.sv
// Package: shared types for the embedded-clock lock detector.
// Assumes one frame = start bit, DATA_W data bits, stop bit.
package edlk_pkg;

    // Lock controller states: searching, aligned but not yet announced, locked.
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LOCKED = 2'd2
    } lock_st_e;

endpackage

// File: rtl/edlk_framer.sv
// Module: edlk_framer
// Keeps the running bit phase within a frame, the previous bit and a window
// of the most recent FRAME_BITS-1 bits. Assumes bit_vld marks each new bit;
// clr_i (power-down) returns everything to its reset value.
module edlk_framer #(
    parameter int FRAME_BITS = 18,
    parameter int PH_W       = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  ser_bit_i,
    input  logic                  bit_vld_i,
    output logic [PH_W-1:0]       ph_o,
    output logic                  prev_o,
    output logic [FRAME_BITS-2:0] win_o
);

    logic [PH_W-1:0]       ph_q;
    logic                  prev_q;
    logic [FRAME_BITS-2:0] win_q;

    // Advance phase and shift the bit window on every accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            ph_q   <= '0;
            prev_q <= 1'b0;
            win_q  <= '0;
        end else if (bit_vld_i) begin
            ph_q   <= (ph_q == PH_W'(FRAME_BITS - 1)) ? '0 : ph_q + 1'b1;
            prev_q <= ser_bit_i;
            win_q  <= {win_q[FRAME_BITS-3:0], ser_bit_i};
        end
    end

    assign ph_o   = ph_q;
    assign prev_o = prev_q;
    assign win_o  = win_q;

    // R8: idle cycles leave the phase untouched.
    a_r8_idle_holds_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld_i && !clr_i) |=> $stable(ph_q));

endmodule

// File: rtl/edlk_search.sv
// Module: edlk_search
// Tracks every frame phase as a boundary candidate. A candidate is dropped
// the first time its bit position lacks a 0-to-1 step. Counts whole frames
// since the last restart (saturating at LOCK_FRAMES). Restarts when all
// candidates are gone or when clr_i is raised.
module edlk_search #(
    parameter int FRAME_BITS  = 18,
    parameter int LOCK_FRAMES = 150,
    parameter int PH_W        = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  bit_vld_i,
    input  logic [PH_W-1:0]       ph_i,
    input  logic                  edge_i,
    output logic                  qual_o,
    output logic                  full_o,
    output logic [PH_W-1:0]       idx_o,
    output logic [FRAME_BITS-1:0] cand_o
);

    localparam int CNT_W = $clog2(LOCK_FRAMES + 1);

    logic [FRAME_BITS-1:0] cand_q;
    logic [CNT_W-1:0]      frm_cnt_q;
    logic                  restart;

    assign restart = clr_i | (cand_q == '0);

    // One survivor bit per phase, each cleared on a missing edge at its phase.
    for (genvar p = 0; p < FRAME_BITS; p++) begin : g_cand
        always_ff @(posedge clk) begin
            if (!rst_n || restart) begin
                cand_q[p] <= 1'b1;
            end else if (bit_vld_i && (ph_i == PH_W'(p)) && !edge_i) begin
                cand_q[p] <= 1'b0;
            end
        end
    end

    // Count completed frames since the last restart, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            frm_cnt_q <= '0;
        end else if (bit_vld_i && (ph_i == PH_W'(FRAME_BITS - 1))
                     && (frm_cnt_q != CNT_W'(LOCK_FRAMES))) begin
            frm_cnt_q <= frm_cnt_q + 1'b1;
        end
    end

    // Encode the position of the surviving candidate.
    always_comb begin
        idx_o = '0;
        for (int p = 0; p < FRAME_BITS; p++) begin
            if (cand_q[p]) idx_o = PH_W'(p);
        end
    end

    assign full_o = (frm_cnt_q == CNT_W'(LOCK_FRAMES));
    assign qual_o = full_o && $onehot(cand_q);
    assign cand_o = cand_q;

    // R6: a clear empties the frame count on the next cycle.
    a_r6_clear_resets_count: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (frm_cnt_q == '0));

endmodule

// File: rtl/edlk_lock_ctrl.sv
// Module: edlk_lock_ctrl
// Takes the phase qualified by the search, watches the start-bit edge at
// that phase, drops lock after MISS_LIMIT consecutive misses, and emits one
// word with a strobe on every stop bit once aligned. lock_n falls together
// with the first strobe. Assumes FRAME_BITS = DATA_W + 2.
module edlk_lock_ctrl
    import edlk_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FRAME_BITS = DATA_W + 2,
    parameter int MISS_LIMIT = 2,
    parameter int PH_W       = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  bit_vld_i,
    input  logic [PH_W-1:0]       ph_i,
    input  logic                  edge_i,
    input  logic [FRAME_BITS-2:0] win_i,
    input  logic                  qual_i,
    input  logic [PH_W-1:0]       idx_i,
    output logic [DATA_W-1:0]     word_o,
    output logic                  stb_o,
    output logic                  lock_n_o,
    output logic                  aligned_o,
    output logic                  drop_o
);

    localparam int MISS_W = $clog2(MISS_LIMIT + 1);

    lock_st_e          state_q;
    logic [PH_W-1:0]   start_ph_q;
    logic [PH_W-1:0]   stop_ph_q;
    logic [MISS_W-1:0] miss_q;
    logic [DATA_W-1:0] word_q;
    logic              stb_q;
    logic              lock_n_q;
    logic [DATA_W-1:0] word_now;
    logic              active;
    logic              hit_start;
    logic              hit_stop;

    // Data bit i sits DATA_W-1-i places behind the stop bit in the window.
    for (genvar i = 0; i < DATA_W; i++) begin : g_unpack
        assign word_now[i] = win_i[DATA_W-1-i];
    end

    assign active    = (state_q != ST_SEARCH);
    assign hit_start = bit_vld_i && (ph_i == start_ph_q);
    assign hit_stop  = bit_vld_i && (ph_i == stop_ph_q);
    assign drop_o    = active && hit_start && !edge_i
                       && (miss_q == MISS_W'(MISS_LIMIT - 1));

    // Lock state, miss counting and word delivery.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            state_q    <= ST_SEARCH;
            start_ph_q <= '0;
            stop_ph_q  <= '0;
            miss_q     <= '0;
            word_q     <= '0;
            stb_q      <= 1'b0;
            lock_n_q   <= 1'b1;
        end else begin
            stb_q <= 1'b0;
            if (state_q == ST_SEARCH) begin
                if (qual_i) begin
                    state_q    <= ST_ARMED;
                    start_ph_q <= idx_i;
                    stop_ph_q  <= (idx_i == '0) ? PH_W'(FRAME_BITS - 1)
                                                : idx_i - 1'b1;
                    miss_q     <= '0;
                end
            end else if (drop_o) begin
                state_q  <= ST_SEARCH;
                lock_n_q <= 1'b1;
                miss_q   <= '0;
            end else begin
                if (hit_start) begin
                    miss_q <= edge_i ? '0 : miss_q + 1'b1;
                end
                if (hit_stop) begin
                    stb_q    <= 1'b1;
                    word_q   <= word_now;
                    lock_n_q <= 1'b0;
                    state_q  <= ST_LOCKED;
                end
            end
        end
    end

    assign word_o    = word_q;
    assign stb_o     = stb_q;
    assign lock_n_o  = lock_n_q;
    assign aligned_o = active;

    // R1: a strobe lasts exactly one cycle.
    a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |=> !stb_q);

    // R3: the lock flag only falls together with a strobe.
    a_r3_lock_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n_q) |-> stb_q);

    // R5: the second missing edge releases lock on the next cycle.
    a_r5_drop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_o && !clr_i) |=> (lock_n_q && state_q == ST_SEARCH));

    // R6: power-down leaves no lock and no strobe behind.
    a_r6_power_down_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (lock_n_q && !stb_q));

endmodule

// File: rtl/edser_lock_rx.sv
// Module: edser_lock_rx
// Top of the embedded-clock deserializer lock detector. Connects the
// framer, the phase search and the lock controller, and gates the outputs
// with output enable and receive power-down. Assumes ser_bit is already
// sampled at the bit rate. When the outputs are not driven they rest at
// 0 / 0 / 1 and out_oe is low.
module edser_lock_rx #(
    parameter int DATA_W      = 16,
    parameter int LOCK_FRAMES = 150,
    parameter int MISS_LIMIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    input  logic              bit_vld,
    input  logic              rx_pwr_n,
    input  logic              out_en,
    output logic [DATA_W-1:0] word_out,
    output logic              word_stb,
    output logic              lock_n,
    output logic              out_oe
);

    localparam int FRAME_BITS = DATA_W + 2;
    localparam int PH_W       = $clog2(FRAME_BITS);

    logic                  clr;
    logic [PH_W-1:0]       ph;
    logic                  prev_bit;
    logic [FRAME_BITS-2:0] win;
    logic                  bit_edge;
    logic                  qual;
    logic                  full;
    logic [PH_W-1:0]       idx;
    logic [FRAME_BITS-1:0] cand;
    logic [DATA_W-1:0]     word_q;
    logic                  stb_q;
    logic                  lock_n_q;
    logic                  aligned;
    logic                  drop;

    assign clr      = !rx_pwr_n;
    assign bit_edge = !prev_bit && ser_bit;

    edlk_framer #(
        .FRAME_BITS (FRAME_BITS),
        .PH_W       (PH_W)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .ser_bit_i (ser_bit),
        .bit_vld_i (bit_vld),
        .ph_o      (ph),
        .prev_o    (prev_bit),
        .win_o     (win)
    );

    edlk_search #(
        .FRAME_BITS  (FRAME_BITS),
        .LOCK_FRAMES (LOCK_FRAMES),
        .PH_W        (PH_W)
    ) u_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr | drop),
        .bit_vld_i (bit_vld),
        .ph_i      (ph),
        .edge_i    (bit_edge),
        .qual_o    (qual),
        .full_o    (full),
        .idx_o     (idx),
        .cand_o    (cand)
    );

    edlk_lock_ctrl #(
        .DATA_W     (DATA_W),
        .FRAME_BITS (FRAME_BITS),
        .MISS_LIMIT (MISS_LIMIT),
        .PH_W       (PH_W)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .bit_vld_i (bit_vld),
        .ph_i      (ph),
        .edge_i    (bit_edge),
        .win_i     (win),
        .qual_i    (qual),
        .idx_i     (idx),
        .word_o    (word_q),
        .stb_o     (stb_q),
        .lock_n_o  (lock_n_q),
        .aligned_o (aligned),
        .drop_o    (drop)
    );

    // Output gating: park at inactive values when not driven.
    assign out_oe   = out_en && rx_pwr_n;
    assign word_out = out_oe ? word_q : '0;
    assign word_stb = out_oe && stb_q;
    assign lock_n   = out_oe ? lock_n_q : 1'b1;

    // R2: alignment only starts after a full count of frames.
    a_r2_align_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> $past(full));

    // R4: alignment only starts with a single surviving candidate.
    a_r4_single_survivor: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> $past($onehot(cand)));

endmodule

// File: tb/tb_edser_lock_rx.sv
module tb_edser_lock_rx;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int LOCKF      = 150;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_bit = 1'b0;
    logic          bit_vld = 1'b0;
    logic          rx_pwr_n = 1'b1;
    logic          out_en = 1'b1;
    logic [DW-1:0] word_out;
    logic          word_stb;
    logic          lock_n;
    logic          out_oe;

    int            n_chk = 0;
    int            n_fail = 0;
    int            stb_cnt = 0;
    logic [DW-1:0] last_word = '0;
    logic          lock_at_stb = 1'b1;

    edser_lock_rx #(
        .DATA_W      (DW),
        .LOCK_FRAMES (LOCKF),
        .MISS_LIMIT  (2)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_bit  (ser_bit),
        .bit_vld  (bit_vld),
        .rx_pwr_n (rx_pwr_n),
        .out_en   (out_en),
        .word_out (word_out),
        .word_stb (word_stb),
        .lock_n   (lock_n),
        .out_oe   (out_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record strobes away from the active edge.
    always @(negedge clk) begin
        if (word_stb) begin
            stb_cnt     <= stb_cnt + 1;
            last_word   <= word_out;
            lock_at_stb <= lock_n;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rx_pwr_n = 1'b1; out_en = 1'b1; bit_vld = 1'b0; ser_bit = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; stb_cnt = 0;
        #1;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); ser_bit = b; bit_vld = 1'b1;
        @(posedge clk); #1; bit_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk); bit_vld = 1'b0;
            @(posedge clk); #1;
        end
    endtask

    // Frame: start (or a missing start), data LSB first, stop 0.
    task automatic send_frame(input logic st, input logic [DW-1:0] d, input int gap_at);
        for (int k = 0; k < DW + 2; k++) begin
            if (k == gap_at) idle(3);
            if (k == 0)           send_bit(st);
            else if (k == DW + 1) send_bit(1'b0);
            else                  send_bit(d[k-1]);
        end
    endtask

    task automatic send_sync(input int n);
        for (int f = 0; f < n; f++) send_frame(1'b1, '0, -1);
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk(lock_n == 1'b1, "R2", "lock_n after reset", lock_n, 1);
        chk(word_stb == 1'b0, "R2", "strobe after reset", word_stb, 0);
        chk(word_out == '0, "R2", "word after reset", word_out, 0);
        chk(out_oe == 1'b1, "R7", "oe after reset", out_oe, 1);
    endtask

    task automatic t_sync_lock();
        send_sync(LOCKF);
        settle();
        chk(lock_n == 1'b1, "R2", "lock_n after threshold frames", lock_n, 1);
        chk(stb_cnt == 0, "R3", "strobes before lock", stb_cnt, 0);
        send_frame(1'b1, 16'h1234, -1);
        chk(word_stb == 1'b1, "R1", "strobe on stop bit", word_stb, 1);
        chk(lock_n == 1'b0, "R2", "lock_n after next frame", lock_n, 0);
        settle();
        chk(lock_at_stb == 1'b0, "R3", "lock_n at first strobe", lock_at_stb, 0);
        chk(last_word == 16'h1234, "R1", "first word", last_word, 16'h1234);
        @(posedge clk); #1;
        chk(word_stb == 1'b0, "R1", "strobe width", word_stb, 0);
    endtask

    task automatic t_data_words();
        int base;
        base = stb_cnt;
        send_frame(1'b1, 16'hA5C3, -1); settle();
        chk(last_word == 16'hA5C3, "R1", "word A5C3", last_word, 16'hA5C3);
        send_frame(1'b1, 16'h8001, 9); settle();
        chk(last_word == 16'h8001, "R8", "word with idle gap", last_word, 16'h8001);
        send_frame(1'b1, 16'hFFFF, 0); settle();
        chk(last_word == 16'hFFFF, "R8", "word after gap at start", last_word, 16'hFFFF);
        chk(stb_cnt == base + 3, "R1", "one strobe per frame", stb_cnt, base + 3);
        chk(lock_n == 1'b0, "R8", "lock held across gaps", lock_n, 0);
    endtask

    task automatic t_oe();
        int base;
        @(negedge clk); out_en = 1'b0; #1;
        chk(out_oe == 1'b0, "R7", "oe with enable low", out_oe, 0);
        chk(lock_n == 1'b1, "R7", "lock_n parked", lock_n, 1);
        chk(word_out == '0, "R7", "word parked", word_out, 0);
        base = stb_cnt;
        send_frame(1'b1, 16'h3C5A, -1); settle();
        chk(stb_cnt == base, "R7", "strobe suppressed", stb_cnt, base);
        out_en = 1'b1; #1;
        chk(lock_n == 1'b0, "R7", "lock kept inside", lock_n, 0);
        chk(word_out == 16'h3C5A, "R7", "word taken while parked", word_out, 16'h3C5A);
    endtask

    task automatic t_miss();
        int base;
        send_frame(1'b0, '0, -1);
        send_frame(1'b1, 16'h0F0F, -1); settle();
        chk(lock_n == 1'b0, "R5", "single miss tolerated", lock_n, 0);
        chk(last_word == 16'h0F0F, "R5", "word after single miss", last_word, 16'h0F0F);
        send_frame(1'b0, '0, -1);
        send_bit(1'b0);
        chk(lock_n == 1'b1, "R5", "lock_n after second miss", lock_n, 1);
        for (int k = 1; k < DW + 2; k++) send_bit(1'b0);
        settle();
        base = stb_cnt;
        send_frame(1'b1, 16'h0000, -1); settle();
        chk(stb_cnt == base, "R3", "no strobe while searching", stb_cnt, base);
        send_sync(LOCKF + 1); settle();
        chk(lock_n == 1'b0, "R5", "relock after restart", lock_n, 0);
    endtask

    task automatic t_rmt();
        do_reset();
        for (int f = 0; f < 200; f++) send_frame(1'b1, 16'h0002, -1);
        settle();
        chk(lock_n == 1'b1, "R4", "no lock on two candidates", lock_n, 1);
        chk(stb_cnt == 0, "R4", "no strobe on two candidates", stb_cnt, 0);
        send_sync(2); settle();
        chk(lock_n == 1'b0, "R4", "lock after pattern change", lock_n, 0);
    endtask

    task automatic t_pwr();
        @(negedge clk); rx_pwr_n = 1'b0; #1;
        chk(out_oe == 1'b0, "R6", "oe in power-down", out_oe, 0);
        chk(lock_n == 1'b1, "R6", "lock_n in power-down", lock_n, 1);
        chk(word_out == '0, "R6", "word in power-down", word_out, 0);
        repeat (3) @(posedge clk);
        @(negedge clk); rx_pwr_n = 1'b1; #1;
        send_sync(1); settle();
        chk(lock_n == 1'b1, "R6", "state cleared by power-down", lock_n, 1);
        send_sync(LOCKF + 1); settle();
        chk(lock_n == 1'b0, "R6", "lock after re-initialisation", lock_n, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog: actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_sync_lock();
        t_data_words();
        t_oe();
        t_miss();
        t_rmt();
        t_pwr();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule